// File: doc/BRIEF.md
# Clock Source Enable and Switch Controller

This block manages three clock sources: an on-chip RC oscillator, an external oscillator and a frequency-multiplying PLL. Software turns each source on through a control register and watches a paired ready flag that the block raises once the source has settled. Oscillator start-up and PLL lock are modelled as cycle counters whose lengths are parameters. A second register holds the PLL input choice, an optional halving of the external clock ahead of the PLL, the multiplier code, a requested system-clock source and a read-only status field.

The status field follows the request only when the requested source is enabled and ready. Otherwise it keeps naming the source that already drives the system clock. The block refuses any write that would switch off the active source, or the oscillator feeding the PLL while the PLL is active. It also ignores writes to the PLL setup fields while the PLL is on. The status value is driven out on `sys_sel` for a downstream clock mux, and the three ready flags are driven out as well.

Top module: `clksrc_ctrl`

## Requirements
- R1: After reset the control word (offset 0x0) reads 0x00000083: internal enable bit 0 = 1, internal ready bit 1 = 1, and a trim field in bits [7:3] = 0x10. The configuration word (offset 0x4) reads 0x00000000, `sys_sel` is 0, `int_ready` is 1, and `ext_ready` and `pll_ready` are 0.
- R2: The ready flags (control bits 1, 17 and 25) and the status field (configuration bits [3:2]) are read-only. Writes to them have no effect.
- R3: With the external enable (control bit 16) set, `ext_ready` rises EXT_START cycles after the write edge. When bypass (control bit 18) is set, it rises BYP_START cycles after the write edge instead. The internal source uses INT_START cycles.
- R4: `pll_ready` (control bit 25) rises PLL_LOCK cycles after the PLL enable (bit 24) and its selected input are both on and ready. The input is chosen by configuration bit 16: 1 selects the external source, 0 selects the internal source. `pll_ready` never rises while that input is not ready.
- R5: Clearing an enable bit drops its ready flag by the next cycle.
- R6: The PLL setup fields are configuration bit 16 (input), bit 17 (external halve) and bits [21:18] (multiplier). Writes to them are ignored while the PLL enable is set and take effect while it is clear.
- R7: Writes to the bypass bit are ignored while the external enable is set.
- R8: The request field is configuration bits [1:0]. Code 0 is internal, 1 is external, 2 is PLL and 3 is reserved. The status field takes the requested code one cycle after the write if that source is enabled and ready. Otherwise it keeps its previous value, and code 3 is never adopted.
- R9: A pending request is adopted one cycle after its source becomes enabled and ready.
- R10: A write that clears the enable of the source in the status field is refused, and the bit stays set. While the status is PLL, the same applies to the PLL enable and to the enable of the PLL's selected input.
- R11: `sys_sel` equals the status field, and the ready outputs equal the ready flags.
- R12: Addresses other than 0x0 and 0x4 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sys_sel | output | 2 | Active system clock source code |
| int_ready | output | 1 | Internal oscillator ready |
| ext_ready | output | 1 | External oscillator ready |
| pll_ready | output | 1 | PLL locked |

## Verification
The assertions check four rules on every cycle. A status change must land on the code that was requested and was usable one cycle earlier. A PLL-sourced status must always coincide with an enabled, locked PLL. Ready flags never rise without their enable and fall one cycle after it. The PLL setup fields stay frozen while the PLL runs. Other behaviour can only be shown by the bench's scenarios: the exact start-up and lock latencies, the bypass timing, a lock that waits on a late input, refused writes read back through the bus, and the random request sequences compared against the expected status.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_PLL = 2'd2,
    SRC_RSV = 2'd3
  } src_e;

  // control word bit positions
  localparam int C_INT_EN  = 0;
  localparam int C_INT_RDY = 1;
  localparam int C_TRIM_LO = 3;
  localparam int C_EXT_EN  = 16;
  localparam int C_EXT_RDY = 17;
  localparam int C_EXT_BYP = 18;
  localparam int C_PLL_EN  = 24;
  localparam int C_PLL_RDY = 25;

  // configuration word bit positions
  localparam int G_REQ_LO  = 0;
  localparam int G_STAT_LO = 2;
  localparam int G_PSRC    = 16;
  localparam int G_XDIV    = 17;
  localparam int G_MUL_LO  = 18;

  localparam logic [4:0] TRIM_RST = 5'h10;

endpackage

// File: rtl/clksrc_rst_sync.sv
module clksrc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/clksrc_osc.sv
module clksrc_osc #(
  parameter int CNT_W   = 5,
  parameter bit RST_RDY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             src_ok_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             rdy_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;
  logic             run;

  always_comb begin
    run   = en_i && src_ok_i;
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!run) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (!rdy_q) begin
      cnt_d = cnt_q + 1'b1;
      rdy_d = (cnt_q == limit_i - 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= RST_RDY;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign rdy_o = rdy_q;

endmodule

// File: rtl/clksrc_switch.sv
module clksrc_switch
  import clksrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  input  logic       use_int_i,
  input  logic       use_ext_i,
  input  logic       use_pll_i,
  output logic [1:0] stat_o,
  output logic [1:0] stat_nxt_o
);

  logic [1:0] stat_q, stat_d;
  logic       tgt_ok;

  always_comb begin
    case (req_i)
      SRC_INT: tgt_ok = use_int_i;
      SRC_EXT: tgt_ok = use_ext_i;
      SRC_PLL: tgt_ok = use_pll_i;
      default: tgt_ok = 1'b0;
    endcase
    stat_d = tgt_ok ? req_i : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= SRC_INT;
    else        stat_q <= stat_d;
  end

  assign stat_o     = stat_q;
  assign stat_nxt_o = stat_d;

endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
  import clksrc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTL_OFF   = 0,
  parameter int CFG_OFF   = 4,
  parameter int INT_START = 4,
  parameter int EXT_START = 12,
  parameter int BYP_START = 2,
  parameter int PLL_LOCK  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        sys_sel,
  output logic              int_ready,
  output logic              ext_ready,
  output logic              pll_ready
);

  localparam int MAX_A = (INT_START > EXT_START) ? INT_START : EXT_START;
  localparam int MAX_B = (BYP_START > PLL_LOCK)  ? BYP_START : PLL_LOCK;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic rst_sync_n;

  // state registers
  logic       int_en_q, int_en_d;
  logic       ext_en_q, ext_en_d;
  logic       byp_q, byp_d;
  logic       pll_en_q, pll_en_d;
  logic [4:0] trim_q, trim_d;
  logic [1:0] req_q, req_d;
  logic       psrc_q, psrc_d;
  logic       xdiv_q, xdiv_d;
  logic [3:0] mul_q, mul_d;

  logic       int_rdy, ext_rdy, pll_rdy;
  logic       use_int, use_ext, use_pll, pll_in_ok;
  logic [1:0] stat, stat_nxt;
  logic       wr_ctl, wr_cfg;
  logic       keep_int, keep_ext, keep_pll;
  logic [CNT_W-1:0] ext_limit;

  clksrc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign use_int   = int_en_q && int_rdy;
  assign use_ext   = ext_en_q && ext_rdy;
  assign pll_in_ok = psrc_q ? use_ext : use_int;
  assign use_pll   = pll_en_q && pll_rdy && pll_in_ok;
  assign ext_limit = byp_q ? CNT_W'(BYP_START) : CNT_W'(EXT_START);

  clksrc_osc #(.CNT_W(CNT_W), .RST_RDY(1'b1)) u_int_osc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (int_en_q),
    .src_ok_i (1'b1),
    .limit_i  (CNT_W'(INT_START)),
    .rdy_o    (int_rdy)
  );

  clksrc_osc #(.CNT_W(CNT_W), .RST_RDY(1'b0)) u_ext_osc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (ext_en_q),
    .src_ok_i (1'b1),
    .limit_i  (ext_limit),
    .rdy_o    (ext_rdy)
  );

  clksrc_osc #(.CNT_W(CNT_W), .RST_RDY(1'b0)) u_pll (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (pll_en_q),
    .src_ok_i (pll_in_ok),
    .limit_i  (CNT_W'(PLL_LOCK)),
    .rdy_o    (pll_rdy)
  );

  clksrc_switch u_switch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_i      (req_q),
    .use_int_i  (use_int),
    .use_ext_i  (use_ext),
    .use_pll_i  (use_pll),
    .stat_o     (stat),
    .stat_nxt_o (stat_nxt)
  );

  // next-state logic
  always_comb begin
    wr_ctl   = bus_wr && (bus_addr == ADDR_W'(CTL_OFF));
    wr_cfg   = bus_wr && (bus_addr == ADDR_W'(CFG_OFF));
    keep_pll = (stat_nxt == SRC_PLL);
    keep_int = (stat_nxt == SRC_INT) || (keep_pll && !psrc_q);
    keep_ext = (stat_nxt == SRC_EXT) || (keep_pll &&  psrc_q);

    int_en_d = int_en_q;
    ext_en_d = ext_en_q;
    pll_en_d = pll_en_q;
    byp_d    = byp_q;
    trim_d   = trim_q;
    req_d    = req_q;
    psrc_d   = psrc_q;
    xdiv_d   = xdiv_q;
    mul_d    = mul_q;

    if (wr_ctl) begin
      int_en_d = bus_wdata[C_INT_EN] || keep_int;
      ext_en_d = bus_wdata[C_EXT_EN] || keep_ext;
      pll_en_d = bus_wdata[C_PLL_EN] || keep_pll;
      trim_d   = bus_wdata[C_TRIM_LO +: 5];
      if (!ext_en_q) byp_d = bus_wdata[C_EXT_BYP];
    end

    if (wr_cfg) begin
      req_d = bus_wdata[G_REQ_LO +: 2];
      if (!pll_en_q) begin
        psrc_d = bus_wdata[G_PSRC];
        xdiv_d = bus_wdata[G_XDIV];
        mul_d  = bus_wdata[G_MUL_LO +: 4];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      int_en_q <= 1'b1;
      ext_en_q <= 1'b0;
      pll_en_q <= 1'b0;
      byp_q    <= 1'b0;
      trim_q   <= TRIM_RST;
      req_q    <= SRC_INT;
      psrc_q   <= 1'b0;
      xdiv_q   <= 1'b0;
      mul_q    <= 4'd0;
    end else begin
      int_en_q <= int_en_d;
      ext_en_q <= ext_en_d;
      pll_en_q <= pll_en_d;
      byp_q    <= byp_d;
      trim_q   <= trim_d;
      req_q    <= req_d;
      psrc_q   <= psrc_d;
      xdiv_q   <= xdiv_d;
      mul_q    <= mul_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = 32'd0;
    if (bus_addr == ADDR_W'(CTL_OFF)) begin
      bus_rdata[C_INT_EN]       = int_en_q;
      bus_rdata[C_INT_RDY]      = int_rdy;
      bus_rdata[C_TRIM_LO +: 5] = trim_q;
      bus_rdata[C_EXT_EN]       = ext_en_q;
      bus_rdata[C_EXT_RDY]      = ext_rdy;
      bus_rdata[C_EXT_BYP]      = byp_q;
      bus_rdata[C_PLL_EN]       = pll_en_q;
      bus_rdata[C_PLL_RDY]      = pll_rdy;
    end else if (bus_addr == ADDR_W'(CFG_OFF)) begin
      bus_rdata[G_REQ_LO +: 2]  = req_q;
      bus_rdata[G_STAT_LO +: 2] = stat;
      bus_rdata[G_PSRC]         = psrc_q;
      bus_rdata[G_XDIV]         = xdiv_q;
      bus_rdata[G_MUL_LO +: 4]  = mul_q;
    end
  end

  assign sys_sel   = stat;
  assign int_ready = int_rdy;
  assign ext_ready = ext_rdy;
  assign pll_ready = pll_rdy;

endmodule

// File: rtl/clksrc_ctrl_chk.sv
module clksrc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       int_en,
  input logic       ext_en,
  input logic       pll_en,
  input logic       int_rdy,
  input logic       ext_rdy,
  input logic       pll_rdy,
  input logic       psrc,
  input logic [1:0] req,
  input logic [1:0] stat,
  input logic [5:0] pll_cfg
);

  logic req_ok;
  logic pll_in_rdy;

  always_comb begin
    case (req)
      2'd0:    req_ok = int_en && int_rdy;
      2'd1:    req_ok = ext_en && ext_rdy;
      2'd2:    req_ok = pll_en && pll_rdy;
      default: req_ok = 1'b0;
    endcase
    pll_in_rdy = psrc ? ext_rdy : int_rdy;
  end

  // R3: a ready flag rises only while its enable was set
  a_r3_ext_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_rdy) |-> $past(ext_en));

  // R4: lock begins only with PLL enabled and its input ready
  a_r4_pll_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rdy) |-> $past(pll_en && pll_in_rdy));

  // R5: a cleared enable drops its flag next cycle
  a_r5_int_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !int_rdy);
  a_r5_ext_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |=> !ext_rdy);
  a_r5_pll_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |=> !pll_rdy);

  // R6: PLL setup frozen while PLL enabled
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pll_en) |-> $stable(pll_cfg));

  // R8: status moves only to a requested, usable source
  a_r8_stat_move: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat) |-> (stat == $past(req)) && $past(req_ok));

  a_r8_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    stat != 2'd3);

  // R10: active source can never be switched off
  a_r10_pll_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 2'd2) |-> pll_en && pll_rdy);
  a_r10_int_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 2'd0) |-> int_en && int_rdy);

endmodule

bind clksrc_ctrl clksrc_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .int_en  (int_en_q),
  .ext_en  (ext_en_q),
  .pll_en  (pll_en_q),
  .int_rdy (int_rdy),
  .ext_rdy (ext_rdy),
  .pll_rdy (pll_rdy),
  .psrc    (psrc_q),
  .req     (req_q),
  .stat    (stat),
  .pll_cfg ({mul_q, xdiv_q, psrc_q})
);

// File: tb/clksrc_ctrl_tb.sv
`timescale 1ns/1ps
module clksrc_ctrl_tb;

  localparam int INT_T = 4;
  localparam int EXT_T = 12;
  localparam int BYP_T = 2;
  localparam int PLL_T = 20;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  sys_sel;
  logic        int_ready, ext_ready, pll_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  clksrc_ctrl #(
    .ADDR_W(4), .CTL_OFF(0), .CFG_OFF(4),
    .INT_START(INT_T), .EXT_START(EXT_T), .BYP_START(BYP_T), .PLL_LOCK(PLL_T)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_sel(sys_sel),
    .int_ready(int_ready), .ext_ready(ext_ready), .pll_ready(pll_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles from the write edge until the selected flag is seen
  task automatic measure(input int which, output int k);
    k = 0;
    while (k < 500 && !((which == 0 && int_ready) || (which == 1 && ext_ready) ||
                        (which == 2 && pll_ready))) begin
      @(negedge clk);
      k++;
    end
  endtask

  function automatic logic [1:0] exp_stat(input logic [1:0] req, input logic [1:0] prev,
                                          input logic [2:0] usable);
    if (req != 2'd3 && usable[req]) return req;
    return prev;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  prev, rq, e;
    int k;
    int seed;
    seed = $urandom(32'h5EED);
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(4);

    // R1 reset state
    rd(4'h0, d); check("R1 ctl reset", d, 32'h00000083);
    rd(4'h4, d); check("R1 cfg reset", d, 32'h0);
    check("R1 sys_sel reset", {30'd0, sys_sel}, 32'd0);
    check("R1 ready outputs", {29'd0, int_ready, ext_ready, pll_ready}, 32'h4);

    // R2 read-only flags and status
    wr(4'h0, 32'h02020083); step(1);
    rd(4'h0, d); check("R2 ready flags ignore writes", d, 32'h00000083);
    wr(4'h4, 32'h0000000C); step(1);
    rd(4'h4, d); check("R2 status ignores writes", d, 32'h0);

    // R12 unmapped
    wr(4'h8, 32'hFFFFFFFF);
    rd(4'h8, d); check("R12 unmapped reads zero", d, 32'h0);
    rd(4'h0, d); check("R12 unmapped write no effect", d, 32'h00000083);

    // R3 external start-up
    wr(4'h0, 32'h00010083); measure(1, k);
    check("R3 ext start cycles", k, EXT_T);
    rd(4'h0, d); check("R3 ext ready in ctl", d, 32'h00030083);

    // R5 clear drops ready
    wr(4'h0, 32'h00000083); step(1);
    check("R5 ext ready drops", {31'd0, ext_ready}, 32'd0);

    // R3 bypass timing, R7 bypass lock
    wr(4'h0, 32'h00040083);
    rd(4'h0, d); check("R7 bypass writable when off", d, 32'h00040083);
    wr(4'h0, 32'h00050083); measure(1, k);
    check("R3 bypass start cycles", k, BYP_T);
    wr(4'h0, 32'h00010083);
    rd(4'h0, d); check("R7 bypass held while ext on", d, 32'h00070083);
    wr(4'h0, 32'h00040083); wr(4'h0, 32'h00000083); step(1);
    rd(4'h0, d); check("R7 bypass cleared when off", d, 32'h00000083);

    // R6 PLL setup, R4 lock on internal input
    wr(4'h4, 32'h001C0000);
    rd(4'h4, d); check("R6 cfg applied while PLL off", d, 32'h001C0000);
    wr(4'h0, 32'h01000083); measure(2, k);
    check("R4 lock cycles internal input", k, PLL_T);
    wr(4'h4, 32'h00010000);
    rd(4'h4, d); check("R6 cfg locked while PLL on", d, 32'h001C0000);

    // R8 switch to PLL, R11 output
    wr(4'h4, 32'h001C0002);
    check("R8 status not yet moved", {30'd0, sys_sel}, 32'd0);
    step(1);
    check("R11 sys_sel after switch", {30'd0, sys_sel}, 32'd2);
    rd(4'h4, d); check("R8 status field PLL", d, 32'h001C000A);

    // R10 refusals while PLL active
    wr(4'h0, 32'h00000083); step(1);
    rd(4'h0, d); check("R10 PLL enable kept", d, 32'h03000083);
    wr(4'h0, 32'h01000082); step(1);
    rd(4'h0, d); check("R10 PLL input enable kept", d, 32'h03000083);

    // R4 lock waits for external input; R8 hold; R9 late adoption
    wr(4'h4, 32'h001C0000); step(1);
    check("R8 back to internal", {30'd0, sys_sel}, 32'd0);
    wr(4'h0, 32'h00000083);
    wr(4'h4, 32'h001D0000);
    wr(4'h0, 32'h01000083); step(40);
    check("R4 no lock without input", {31'd0, pll_ready}, 32'd0);
    wr(4'h4, 32'h001D0002); step(1);
    check("R8 hold on unready target", {30'd0, sys_sel}, 32'd0);
    wr(4'h0, 32'h01010083); measure(2, k);
    check("R4 lock after ext start", k, EXT_T + PLL_T);
    step(1);
    check("R9 pending request adopted", {30'd0, sys_sel}, 32'd2);
    wr(4'h0, 32'h01000083); step(1);
    rd(4'h0, d); check("R10 ext kept as PLL input", d, 32'h03030083);

    // R10 with external active
    wr(4'h4, 32'h001D0001); step(1);
    rd(4'h4, d); check("R8 switch to external", d, 32'h001D0005);
    wr(4'h0, 32'h00010080); step(1);
    rd(4'h0, d); check("R5 int and PLL dropped", d, 32'h00030080);
    wr(4'h4, 32'h001D0000); step(1);
    rd(4'h4, d); check("R8 disabled target refused", d, 32'h001D0004);
    wr(4'h0, 32'h00000080); step(1);
    rd(4'h0, d); check("R10 active ext kept", d, 32'h00030080);

    // random requests, only external usable
    prev = 2'd1;
    for (int i = 0; i < 20; i++) begin
      rq = 2'($urandom_range(0, 3));
      wr(4'h4, 32'h001D0000 | {30'd0, rq}); step(1);
      e = exp_stat(rq, prev, 3'b010);
      rd(4'h4, d); check("R8 random ext-only", d, 32'h001D0000 | {28'd0, e, rq});
      check("R11 random sys_sel", {30'd0, sys_sel}, {30'd0, e});
      prev = e;
    end

    // all sources usable
    wr(4'h0, 32'h01010081); step(40);
    for (int i = 0; i < 30; i++) begin
      rq = 2'($urandom_range(0, 3));
      wr(4'h4, 32'h001D0000 | {30'd0, rq}); step(1);
      e = exp_stat(rq, prev, 3'b111);
      rd(4'h4, d); check("R8 random all usable", d, 32'h001D0000 | {28'd0, e, rq});
      prev = e;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule